// File: doc/BRIEF.md
# Advanced Load Address Table

This block keeps a small associative record of loads that were issued early, ahead of stores that might alias them. Each record holds the destination register number of the load and the address it read, reduced to an 8-byte line. Every store that the core performs is snooped against all live records at once; any record whose line matches the store is removed. Before the early-loaded value is used, the core asks whether the record for that register is still present. A missing record means that a store touched the same line after the load, so the load must be executed again.

A guarded store form also exists. It evicts matching records like an ordinary store, and it additionally raises a conflict pulse when it hits a live record, so that the core can trap instead of relying on a later check. Software can drop one record by register number, or clear the whole table.

The table has a fixed number of slots. A new record for a register that already has a slot reuses that slot. Otherwise it takes the lowest free slot, or, when the table is full, the slot named by a rotating replacement pointer.

Top module: `alat_table`

## Requirements
- R1: After reset every slot is empty, so a check for any register reports absent, and the conflict output is low.
- R2: A check issued in cycle n produces `chk_done` high in cycle n+1, with `chk_present` high only when a live slot holds the requested register; `chk_present` is low whenever `chk_done` is low.
- R3: A store (guarded or not) removes every live slot whose address matches the store address with the low 3 bits ignored, so byte offsets within the same 8-byte line count as a match; a store to another line leaves the table unchanged.
- R4: A record for a register that already has a live slot overwrites that slot, so at most one live slot exists per register and the old address no longer protects it.
- R5: A record for a new register takes the lowest-numbered empty slot; when no slot is empty it replaces the slot given by a replacement pointer that starts at slot 0 after reset and advances by one (wrapping) each time it is used.
- R6: When a record and a store to the same line arrive in the same cycle, the store wins and the new slot is left empty.
- R7: A guarded store that matches a live slot drives `st_conflict` high for exactly the following cycle; a guarded store that matches nothing, or an unguarded store, leaves `st_conflict` low.
- R8: Invalidate-one removes the live slot for the named register and leaves all other slots unchanged.
- R9: Invalidate-all empties every slot; a record in the same cycle is discarded.
- R10: A check reports the table as it stood at the start of its cycle: a record, store or invalidate in the same cycle does not affect that check's answer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_en | input | 1 | Record an early load this cycle |
| rec_reg | input | 7 | Destination register of the recorded load |
| rec_addr | input | 32 | Byte address of the recorded load |
| st_en | input | 1 | A store is being snooped this cycle |
| st_addr | input | 32 | Byte address of the store |
| st_guarded | input | 1 | The store is the guarded form that reports conflicts |
| chk_en | input | 1 | Check request this cycle |
| chk_reg | input | 7 | Register whose record is checked |
| kill_en | input | 1 | Invalidate the record of one register |
| kill_reg | input | 7 | Register whose record is invalidated |
| kill_all | input | 1 | Invalidate every record |
| chk_done | output | 1 | Check response valid (one cycle after request) |
| chk_present | output | 1 | Record still live for the checked register |
| st_conflict | output | 1 | Guarded store hit a live record in the previous cycle |

## Verification
The bench builds the table with its defaults: eight slots, 7-bit register numbers and 32-bit addresses. Eight slots are few enough that directed sequences fill the table and drive the replacement pointer through wrap-around, while a random phase with only four register numbers and four lines makes overwrites, same-cycle record and store collisions, and guarded-store hits frequent. The 3-bit line offset lets directed cases place stores at other bytes of a recorded line and at the first byte of the next line.

// File: rtl/alat_pkg.sv
package alat_pkg;

    // How the allocator chose the slot for a new record.
    typedef enum logic [1:0] {
        PICK_TAG  = 2'd0,   // register already owns a live slot
        PICK_FREE = 2'd1,   // lowest empty slot
        PICK_RR   = 2'd2    // table full, rotating victim
    } pick_e;

    localparam int unsigned DEF_SLOTS    = 8;
    localparam int unsigned DEF_TAG_W    = 7;
    localparam int unsigned DEF_ADDR_W   = 32;
    localparam int unsigned DEF_LINE_LG2 = 3;

endpackage

// File: rtl/alat_tag_cam.sv
module alat_tag_cam #(
    parameter int unsigned SLOTS = 8,
    parameter int unsigned TAG_W = 7
) (
    input  logic [SLOTS-1:0]            vld,
    input  logic [SLOTS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]            key,
    output logic [SLOTS-1:0]            hit
);

    for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
        assign hit[i] = vld[i] && (tags[i] == key);
    end

endmodule

// File: rtl/alat_line_cam.sv
module alat_line_cam #(
    parameter int unsigned SLOTS  = 8,
    parameter int unsigned LINE_W = 29
) (
    input  logic [SLOTS-1:0]             vld,
    input  logic [SLOTS-1:0][LINE_W-1:0] lines,
    input  logic [LINE_W-1:0]            key,
    output logic [SLOTS-1:0]             hit
);

    for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
        assign hit[i] = vld[i] && (lines[i] == key);
    end

endmodule

// File: rtl/alat_victim.sv
module alat_victim
    import alat_pkg::*;
#(
    parameter int unsigned SLOTS = 8,
    localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [SLOTS-1:0] vld,
    input  logic [SLOTS-1:0] tag_hit,
    input  logic [IDX_W-1:0] rr_ptr,
    output logic [IDX_W-1:0] slot,
    output pick_e            pick
);

    logic [IDX_W-1:0] tag_idx;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    // Encoder for the (at most one) slot already owned by the register.
    always_comb begin
        tag_idx = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (tag_hit[i]) tag_idx = IDX_W'(i);
        end
    end

    // Lowest empty slot: scan downwards so the lowest index is kept last.
    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end

    always_comb begin
        if (|tag_hit) begin
            slot = tag_idx;
            pick = PICK_TAG;
        end else if (any_free) begin
            slot = free_idx;
            pick = PICK_FREE;
        end else begin
            slot = rr_ptr;
            pick = PICK_RR;
        end
    end

endmodule

// File: rtl/alat_table.sv
module alat_table
    import alat_pkg::*;
#(
    parameter int unsigned SLOTS    = DEF_SLOTS,
    parameter int unsigned TAG_W    = DEF_TAG_W,
    parameter int unsigned ADDR_W   = DEF_ADDR_W,
    parameter int unsigned LINE_LG2 = DEF_LINE_LG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_en,
    input  logic [TAG_W-1:0]  rec_reg,
    input  logic [ADDR_W-1:0] rec_addr,
    input  logic              st_en,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              st_guarded,
    input  logic              chk_en,
    input  logic [TAG_W-1:0]  chk_reg,
    input  logic              kill_en,
    input  logic [TAG_W-1:0]  kill_reg,
    input  logic              kill_all,
    output logic              chk_done,
    output logic              chk_present,
    output logic              st_conflict
);

    localparam int unsigned LINE_W = ADDR_W - LINE_LG2;
    localparam int unsigned IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

    typedef struct packed {
        logic [SLOTS-1:0]             vld;
        logic [SLOTS-1:0][TAG_W-1:0]  tag;
        logic [SLOTS-1:0][LINE_W-1:0] line;
        logic [IDX_W-1:0]             rr;
        logic                         done;
        logic                         present;
        logic                         conflict;
    } state_t;

    state_t state_d, state_q;

    logic [LINE_W-1:0] rec_line_d;
    logic [LINE_W-1:0] st_line_d;
    logic [SLOTS-1:0]  rec_hit, chk_hit, kill_hit, st_hit;
    logic [IDX_W-1:0]  new_slot;
    pick_e             new_pick;
    logic              same_line;

    assign rec_line_d = LINE_W'(rec_addr >> LINE_LG2);
    assign st_line_d  = LINE_W'(st_addr >> LINE_LG2);
    assign same_line  = st_en && (rec_line_d == st_line_d);

    alat_tag_cam #(.SLOTS(SLOTS), .TAG_W(TAG_W)) u_rec_cam (
        .vld(state_q.vld), .tags(state_q.tag), .key(rec_reg), .hit(rec_hit)
    );

    alat_tag_cam #(.SLOTS(SLOTS), .TAG_W(TAG_W)) u_chk_cam (
        .vld(state_q.vld), .tags(state_q.tag), .key(chk_reg), .hit(chk_hit)
    );

    alat_tag_cam #(.SLOTS(SLOTS), .TAG_W(TAG_W)) u_kill_cam (
        .vld(state_q.vld), .tags(state_q.tag), .key(kill_reg), .hit(kill_hit)
    );

    alat_line_cam #(.SLOTS(SLOTS), .LINE_W(LINE_W)) u_st_cam (
        .vld(state_q.vld), .lines(state_q.line), .key(st_line_d), .hit(st_hit)
    );

    alat_victim #(.SLOTS(SLOTS)) u_victim (
        .vld(state_q.vld), .tag_hit(rec_hit), .rr_ptr(state_q.rr),
        .slot(new_slot), .pick(new_pick)
    );

    always_comb begin
        state_d = state_q;

        // Responses reflect the table at the start of the cycle.
        state_d.done     = chk_en;
        state_d.present  = chk_en && (|chk_hit);
        state_d.conflict = st_en && st_guarded && (|st_hit);

        for (int i = 0; i < SLOTS; i++) begin
            if (st_en && st_hit[i])     state_d.vld[i] = 1'b0;
            if (kill_en && kill_hit[i]) state_d.vld[i] = 1'b0;
        end

        if (kill_all) begin
            state_d.vld = '0;
        end else if (rec_en) begin
            state_d.tag[new_slot]  = rec_reg;
            state_d.line[new_slot] = rec_line_d;
            state_d.vld[new_slot]  = !same_line;
            if (new_pick == PICK_RR) begin
                state_d.rr = (state_q.rr == LAST_IDX) ? '0 : state_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign chk_done    = state_q.done;
    assign chk_present = state_q.present;
    assign st_conflict = state_q.conflict;

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    function automatic logic line_live(input logic [SLOTS-1:0] v,
                                       input logic [SLOTS-1:0][LINE_W-1:0] l,
                                       input logic [LINE_W-1:0] k);
        logic r;
        r = 1'b0;
        for (int i = 0; i < SLOTS; i++) if (v[i] && l[i] == k) r = 1'b1;
        return r;
    endfunction

    function automatic logic tag_live(input logic [SLOTS-1:0] v,
                                      input logic [SLOTS-1:0][TAG_W-1:0] t,
                                      input logic [TAG_W-1:0] k);
        logic r;
        r = 1'b0;
        for (int i = 0; i < SLOTS; i++) if (v[i] && t[i] == k) r = 1'b1;
        return r;
    endfunction

    logic dup_tag;
    always_comb begin
        dup_tag = 1'b0;
        for (int i = 0; i < SLOTS; i++)
            for (int j = i + 1; j < SLOTS; j++)
                if (state_q.vld[i] && state_q.vld[j] && state_q.tag[i] == state_q.tag[j])
                    dup_tag = 1'b1;
    end

    assert_one_slot_per_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !dup_tag);

    assert_resp_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en |=> chk_done);

    assert_no_idle_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_en |=> (!chk_done && !chk_present));

    assert_store_evicts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_en |=> !line_live(state_q.vld, state_q.line, $past(st_line_d)));

    assert_conflict_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_conflict |-> $past(st_en && st_guarded));

    assert_kill_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_en && !rec_en) |=> !tag_live(state_q.vld, state_q.tag, $past(kill_reg)));

    assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        kill_all |=> (state_q.vld == '0));

endmodule

// File: tb/tb_alat_table.sv
module tb_alat_table;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rec_en = 0, st_en = 0, st_guarded = 0, chk_en = 0, kill_en = 0, kill_all = 0;
    logic [6:0]  rec_reg = 0, chk_reg = 0, kill_reg = 0;
    logic [31:0] rec_addr = 0, st_addr = 0;
    logic        chk_done, chk_present, st_conflict;

    always #5 clk = ~clk;

    alat_table dut (
        .clk(clk), .rst_n(rst_n),
        .rec_en(rec_en), .rec_reg(rec_reg), .rec_addr(rec_addr),
        .st_en(st_en), .st_addr(st_addr), .st_guarded(st_guarded),
        .chk_en(chk_en), .chk_reg(chk_reg),
        .kill_en(kill_en), .kill_reg(kill_reg), .kill_all(kill_all),
        .chk_done(chk_done), .chk_present(chk_present), .st_conflict(st_conflict)
    );

    // Behavioural reference: parallel arrays plus a rotating pointer.
    bit          m_v[N];
    int unsigned m_t[N];
    int unsigned m_l[N];
    int          m_ptr;

    int  vectors = 0;
    int  fails   = 0;
    bit  ended   = 0;

    task automatic clear_inputs();
        rec_en = 0; st_en = 0; st_guarded = 0; chk_en = 0; kill_en = 0; kill_all = 0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    // Apply the current inputs for one clock and compare the outputs.
    task automatic tick(input string req);
        bit          e_done, e_hit, e_conf;
        bit          n_v[N];
        int unsigned rl, sl;
        int          slot;
        rl = rec_addr >> 3;
        sl = st_addr >> 3;
        e_done = chk_en;
        e_hit  = 0;
        e_conf = 0;
        for (int i = 0; i < N; i++) begin
            if (chk_en && m_v[i] && m_t[i] == chk_reg) e_hit = 1;
            if (st_en && st_guarded && m_v[i] && m_l[i] == sl) e_conf = 1;
        end
        for (int i = 0; i < N; i++) begin
            n_v[i] = m_v[i];
            if (st_en && m_v[i] && m_l[i] == sl) n_v[i] = 0;
            if (kill_en && m_v[i] && m_t[i] == kill_reg) n_v[i] = 0;
        end
        if (kill_all) begin
            for (int i = 0; i < N; i++) n_v[i] = 0;
        end else if (rec_en) begin
            slot = -1;
            for (int i = 0; i < N; i++) if (m_v[i] && m_t[i] == rec_reg) slot = i;
            if (slot < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
            if (slot < 0) begin
                slot  = m_ptr;
                m_ptr = (m_ptr + 1) % N;
            end
            m_t[slot] = rec_reg;
            m_l[slot] = rl;
            n_v[slot] = !(st_en && sl == rl);
        end
        for (int i = 0; i < N; i++) m_v[i] = n_v[i];

        @(posedge clk);
        #1;
        vectors++;
        if (chk_done !== e_done || chk_present !== e_hit || st_conflict !== e_conf) begin
            fails++;
            $display("FAIL %s: done/present/conflict = %b%b%b expected %b%b%b",
                     req, chk_done, chk_present, st_conflict, e_done, e_hit, e_conf);
        end
        clear_inputs();
    endtask

    task automatic rec(input int r, input int a, input string req);
        rec_en = 1; rec_reg = 7'(r); rec_addr = a; tick(req);
    endtask
    task automatic chk(input int r, input string req);
        chk_en = 1; chk_reg = 7'(r); tick(req);
    endtask
    task automatic st(input int a, input bit g, input string req);
        st_en = 1; st_addr = a; st_guarded = g; tick(req);
    endtask
    task automatic idle(input string req);
        tick(req);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_t[i] = 0; m_l[i] = 0; end
        m_ptr = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: empty after reset
        idle("R1");
        chk(5, "R1");
        chk(0, "R1");

        // R2: record then check, one-cycle response
        rec(3, 'h100, "R2");
        chk(3, "R2");
        idle("R2");

        // R3: same line other byte evicts, other line does not
        st('h104, 0, "R3");
        chk(3, "R3");
        rec(4, 'h200, "R3");
        st('h208, 0, "R3");
        chk(4, "R3");
        st('h207, 0, "R3");
        chk(4, "R3");

        // R4: overwrite of an existing register
        rec(4, 'h300, "R4");
        rec(4, 'h400, "R4");
        st('h300, 0, "R4");
        chk(4, "R4");
        st('h400, 0, "R4");
        chk(4, "R4");

        // R9 then R5: fill, then rotating replacement
        kill_all = 1; tick("R9");
        for (int i = 0; i < N; i++) rec(10 + i, 'h1000 + i * 8, "R5");
        rec(20, 'h2000, "R5");
        chk(10, "R5");
        chk(20, "R5");
        chk(11, "R5");
        rec(21, 'h2008, "R5");
        chk(11, "R5");
        st('h1010, 0, "R5");
        rec(22, 'h2010, "R5");
        chk(22, "R5");
        chk(13, "R5");

        // R6: record and store to the same line in one cycle
        rec_en = 1; rec_reg = 30; rec_addr = 'h500; st_en = 1; st_addr = 'h503; tick("R6");
        chk(30, "R6");
        rec_en = 1; rec_reg = 31; rec_addr = 'h600; st_en = 1; st_addr = 'h700; tick("R6");
        chk(31, "R6");

        // R7: guarded store conflict behaviour
        rec(40, 'h800, "R7");
        st('h808, 1, "R7");
        idle("R7");
        st('h801, 1, "R7");
        idle("R7");
        chk(40, "R7");
        rec(41, 'h900, "R7");
        st('h900, 0, "R7");
        idle("R7");

        // R8: invalidate one register only
        rec(50, 'hA00, "R8");
        rec(51, 'hB00, "R8");
        kill_en = 1; kill_reg = 50; tick("R8");
        chk(50, "R8");
        chk(51, "R8");

        // R9: invalidate all
        kill_all = 1; tick("R9");
        chk(51, "R9");
        chk(31, "R9");

        // R10: check sees table before same-cycle updates
        rec_en = 1; rec_reg = 60; rec_addr = 'hC00; chk_en = 1; chk_reg = 60; tick("R10");
        chk(60, "R10");
        st_en = 1; st_addr = 'hC00; chk_en = 1; chk_reg = 60; tick("R10");
        chk(60, "R10");

        // R9: record in the same cycle as invalidate-all is dropped
        kill_all = 1; rec_en = 1; rec_reg = 70; rec_addr = 'hD00; tick("R9");
        chk(70, "R9");

        // Random mix over a small register and line space (R2..R10)
        for (int n = 0; n < 3000; n++) begin
            rec_en     = ($urandom % 3) == 0;
            rec_reg    = 7'($urandom % 4);
            rec_addr   = ($urandom % 32);
            st_en      = ($urandom % 3) == 0;
            st_addr    = ($urandom % 32);
            st_guarded = $urandom % 2;
            chk_en     = $urandom % 2;
            chk_reg    = 7'($urandom % 5);
            kill_en    = ($urandom % 8) == 0;
            kill_reg   = 7'($urandom % 4);
            kill_all   = ($urandom % 64) == 0;
            tick("R10");
        end

        finish_run();
    end

endmodule